// File: doc/BRIEF.md
# Write-Update Snoopy Coherence Controller

This block keeps the coherence state of a small direct-mapped cache that shares a bus with other caches under a write-update policy. A write to data that other caches also hold sends the new value over the bus, and those caches take the new value instead of dropping their copy. A resident line is always in one of four states: exclusive-clean, shared-clean, shared-owner (this cache must write the line back when it leaves) and modified (the only copy, changed). A slot that has never been filled is empty, and empty is not a state of a resident line.

Each cycle the block takes either one processor access or one snooped bus transaction. For a processor access it reports hit and state, and it issues a bus read-miss, write-miss or update command when one is needed. It also requests a write-back when a miss evicts an owned line. The wired shared line, sampled in the same cycle as the block's own bus command, decides whether the line ends in a shared or a private state. For a snooped transaction that hits a resident line, the block raises the shared line and changes the line's state. Data storage, bus arbitration and victim choice are outside the block. The victim is always the single slot the address maps to.

Top module: `wuCohCtrl`

## Requirements
- R1: After reset every slot is empty. A snooped read miss to any address leaves sharedOut low, and the first processor access to any address misses.
- R2: A processor read miss drives busValid with busCmd=0 (read miss) on busAddr=cpuAddr. The line is filled in state 0 (exclusive-clean) if sharedIn is low, or in state 1 (shared-clean) if sharedIn is high.
- R3: A processor write hit to a line in state 0 or 3 (modified) drives no bus command, and the line becomes state 3.
- R4: A processor write hit to a line in state 1 or 2 (shared-owner) drives busCmd=2 (update). The line becomes state 2 if sharedIn is high, or state 3 if it is low.
- R5: A processor write miss drives busCmd=1 (write miss), and the line is filled in state 2 if sharedIn is high, or in state 3 if it is low.
- R6: A snooped read miss (snpCmd=0) that hits raises sharedOut, moves state 3 to 2 and state 0 to 1, and leaves states 1 and 2 unchanged.
- R7: A snooped write miss (snpCmd=1) that hits raises sharedOut and leaves the line in state 1.
- R8: A snooped update (snpCmd=2) that hits raises sharedOut and leaves the line in state 1. An owner in state 2 therefore gives up ownership.
- R9: A snooped transaction that misses, and any snooped write-back (snpCmd=3), leaves sharedOut low and changes no line.
- R10: A processor miss that evicts a resident line in state 2 or 3 asserts wbValid in the same cycle, with wbAddr set to the victim's tag and index. Evicting a line in state 0 or 1 is silent.
- R11: A processor read hit drives no bus command and leaves the line's state unchanged. On every processor hit, hitState reports the line's current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuValid | input | 1 | Processor access present this cycle |
| cpuWrite | input | 1 | Access is a write (1) or a read (0) |
| cpuAddr | input | ADDR_W | Line address of the access, index in the low bits |
| cpuHit | output | 1 | Access hits a resident line |
| hitState | output | 2 | State of the hit line (0 exclusive-clean, 1 shared-clean, 2 shared-owner, 3 modified) |
| snpValid | input | 1 | Snooped bus transaction present this cycle |
| snpCmd | input | 2 | Snooped command: 0 read miss, 1 write miss, 2 update, 3 write-back |
| snpAddr | input | ADDR_W | Line address of the snooped transaction |
| sharedOut | output | 1 | Drive of the wired shared line |
| sharedIn | input | 1 | Sampled wired shared line for this cache's own command |
| busValid | output | 1 | This cache issues a bus command |
| busCmd | output | 2 | Issued command, same encoding as snpCmd |
| busAddr | output | ADDR_W | Address of the issued command |
| wbValid | output | 1 | Write-back of the evicted owned line requested |
| wbAddr | output | ADDR_W | Address of the evicted line |

## Verification
The assertions assume that a processor access and a snooped transaction never arrive in the same cycle, because bus arbitration outside the block serializes them. They also assume that sharedIn is only meaningful in the cycle of this cache's own command. The bench issues every operation in a cycle of its own and never drives both valids together. Its directed sweep brings each slot into each of the four states through legal processor sequences and then applies every access and snoop kind. A random phase follows that uses only two tags per index, so that hits, conflicts and evictions happen often.

// File: rtl/wuCohPkg.sv
package wuCohPkg;

  typedef enum logic [1:0] {
    ST_VEX  = 2'd0,  // exclusive, clean
    ST_SCLN = 2'd1,  // shared, clean
    ST_SDRT = 2'd2,  // shared, this cache owns the write-back
    ST_DRT  = 2'd3   // only copy, modified
  } lineState_t;

  typedef enum logic [1:0] {
    BC_RDMISS = 2'd0,
    BC_WRMISS = 2'd1,
    BC_UPDATE = 2'd2,
    BC_WBACK  = 2'd3
  } busCmd_t;

  // strobes from control into the tag/state store
  typedef struct packed {
    logic       wrEn;
    logic       fill;
    lineState_t newState;
  } ctlStrobe_t;

endpackage

// File: rtl/wuCohDatapath.sv
module wuCohDatapath
  import wuCohPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lookAddr,
  input  ctlStrobe_t        strobe,
  output logic              hit,
  output logic              slotValid,
  output lineState_t        curState,
  output logic [ADDR_W-1:0] victimAddr
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] lookIdx;
  logic [TAG_W-1:0] lookTag;
  assign lookIdx = lookAddr[IDX_W-1:0];
  assign lookTag = lookAddr[ADDR_W-1:IDX_W];

  logic [LINES-1:0] validV;
  logic [TAG_W-1:0] tagV   [LINES];
  lineState_t       stateV [LINES];

  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic       vQ;
    logic [TAG_W-1:0] tQ;
    lineState_t sQ;
    logic       sel;
    assign sel = strobe.wrEn && (lookIdx == IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vQ <= 1'b0;
        tQ <= '0;
        sQ <= ST_VEX;
      end else if (sel) begin
        sQ <= strobe.newState;
        if (strobe.fill) begin
          vQ <= 1'b1;
          tQ <= lookTag;
        end
      end
    end

    assign validV[g] = vQ;
    assign tagV[g]   = tQ;
    assign stateV[g] = sQ;
  end

  assign slotValid  = validV[lookIdx];
  assign hit        = slotValid && (tagV[lookIdx] == lookTag);
  assign curState   = stateV[lookIdx];
  assign victimAddr = {tagV[lookIdx], lookIdx};

endmodule

// File: rtl/wuCohControl.sv
module wuCohControl
  import wuCohPkg::*;
(
  input  logic       cpuValid,
  input  logic       cpuWrite,
  input  logic       snpValid,
  input  busCmd_t    snpCmd,
  input  logic       sharedIn,
  input  logic       hit,
  input  logic       slotValid,
  input  lineState_t curState,
  output ctlStrobe_t strobe,
  output logic       cpuHit,
  output logic       busValid,
  output busCmd_t    busCmd,
  output logic       wbNeed,
  output logic       sharedOut
);
  logic ownedState;
  assign ownedState = (curState == ST_SDRT) || (curState == ST_DRT);

  always_comb begin
    strobe    = '0;
    cpuHit    = 1'b0;
    busValid  = 1'b0;
    busCmd    = BC_RDMISS;
    wbNeed    = 1'b0;
    sharedOut = 1'b0;
    if (snpValid) begin
      if (hit && snpCmd != BC_WBACK) begin
        sharedOut     = 1'b1;
        strobe.wrEn   = 1'b1;
        if (snpCmd == BC_RDMISS) begin
          unique case (curState)
            ST_DRT:  strobe.newState = ST_SDRT;
            ST_VEX:  strobe.newState = ST_SCLN;
            default: strobe.newState = curState;
          endcase
        end else begin
          strobe.newState = ST_SCLN;
        end
      end
    end else if (cpuValid) begin
      cpuHit = hit;
      if (hit) begin
        if (cpuWrite) begin
          strobe.wrEn = 1'b1;
          if (curState == ST_VEX || curState == ST_DRT) begin
            strobe.newState = ST_DRT;
          end else begin
            busValid        = 1'b1;
            busCmd          = BC_UPDATE;
            strobe.newState = sharedIn ? ST_SDRT : ST_DRT;
          end
        end
      end else begin
        busValid    = 1'b1;
        busCmd      = cpuWrite ? BC_WRMISS : BC_RDMISS;
        strobe.wrEn = 1'b1;
        strobe.fill = 1'b1;
        if (cpuWrite) strobe.newState = sharedIn ? ST_SDRT : ST_DRT;
        else          strobe.newState = sharedIn ? ST_SCLN : ST_VEX;
        wbNeed = slotValid && ownedState;
      end
    end
  end

endmodule

// File: rtl/wuCohCtrl.sv
module wuCohCtrl
  import wuCohPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              cpuHit,
  output logic [1:0]        hitState,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              sharedOut,
  input  logic              sharedIn,
  output logic              busValid,
  output logic [1:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddr
);
  logic [ADDR_W-1:0] lookAddr;
  ctlStrobe_t        strobe;
  logic              hit, slotValid;
  lineState_t        curState;
  busCmd_t           busCmdE;

  assign lookAddr = snpValid ? snpAddr : cpuAddr;

  wuCohDatapath #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dpI (
    .clk(clk), .rstN(rstN), .lookAddr(lookAddr), .strobe(strobe),
    .hit(hit), .slotValid(slotValid), .curState(curState), .victimAddr(wbAddr)
  );

  wuCohControl ctlI (
    .cpuValid(cpuValid), .cpuWrite(cpuWrite), .snpValid(snpValid),
    .snpCmd(busCmd_t'(snpCmd)), .sharedIn(sharedIn), .hit(hit),
    .slotValid(slotValid), .curState(curState), .strobe(strobe),
    .cpuHit(cpuHit), .busValid(busValid), .busCmd(busCmdE),
    .wbNeed(wbValid), .sharedOut(sharedOut)
  );

  assign busCmd   = busCmdE;
  assign busAddr  = cpuAddr;
  assign hitState = cpuHit ? curState : ST_VEX;

endmodule

// File: rtl/wuCohChk.sv
module wuCohChk
  import wuCohPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       cpuValid,
  input logic       cpuWrite,
  input logic       cpuHit,
  input logic [1:0] hitState,
  input logic       snpValid,
  input logic [1:0] snpCmd,
  input logic       sharedOut,
  input logic       busValid,
  input logic [1:0] busCmd,
  input logic       wbValid
);
  // environment: arbitration never presents both sources together
  a_env_one_source: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuValid && snpValid));

  a_r2_miss_goes_to_bus: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && !snpValid && !cpuHit) |-> (busValid && busCmd == (cpuWrite ? 2'd1 : 2'd0)));

  a_r3_private_write_silent: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && cpuWrite && cpuHit && (hitState == ST_VEX || hitState == ST_DRT)) |-> !busValid);

  a_r4_shared_write_updates: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && cpuWrite && cpuHit && (hitState == ST_SCLN || hitState == ST_SDRT))
      |-> (busValid && busCmd == BC_UPDATE));

  a_r9_wback_snoop_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpCmd == BC_WBACK) |-> !sharedOut);

  a_r10_wb_only_on_miss: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (cpuValid && !cpuHit));

  a_r11_read_hit_silent: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && !cpuWrite && cpuHit) |-> !busValid);

  a_r6_shared_only_for_snoop: assert property (@(posedge clk) disable iff (!rstN)
    sharedOut |-> snpValid);

endmodule

bind wuCohCtrl wuCohChk chkI (.*);

// File: tb/tb_wuCohCtrl.sv
module tb_wuCohCtrl;
  import wuCohPkg::*;
  localparam int AW = 6;
  localparam int IW = 2;
  localparam int LN = 1 << IW;
  localparam int TW = AW - IW;

  logic clk = 1'b0, rstN = 1'b0;
  logic cpuValid = 0, cpuWrite = 0, snpValid = 0, sharedIn = 0;
  logic [AW-1:0] cpuAddr = '0, snpAddr = '0;
  logic [1:0] snpCmd = '0;
  logic cpuHit, sharedOut, busValid, wbValid;
  logic [1:0] hitState, busCmd;
  logic [AW-1:0] busAddr, wbAddr;

  wuCohCtrl #(.ADDR_W(AW), .IDX_W(IW)) dut (.*);

  always #2 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;
  logic          mValid [LN];
  logic [TW-1:0] mTag   [LN];
  logic [1:0]    mState [LN];

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doCpu(bit wr, logic [AW-1:0] a, bit sh);
    int i = int'(a[IW-1:0]);
    logic [TW-1:0] t = a[AW-1:IW];
    bit hit = mValid[i] && mTag[i] == t;
    logic [1:0] cur = mState[i];
    logic [1:0] nxt;
    bit expBus;
    int expCmd = 0;
    bit expWb;
    logic [AW-1:0] wbA = {mTag[i], a[IW-1:0]};
    string rq;
    if (hit) begin
      if (!wr) begin rq = "R11"; expBus = 0; nxt = cur; end
      else if (cur == 2'd0 || cur == 2'd3) begin rq = "R3"; expBus = 0; nxt = 2'd3; end
      else begin rq = "R4"; expBus = 1; expCmd = 2; nxt = sh ? 2'd2 : 2'd3; end
    end else begin
      rq = wr ? "R5" : "R2";
      expBus = 1;
      expCmd = wr ? 1 : 0;
      nxt = wr ? (sh ? 2'd2 : 2'd3) : (sh ? 2'd1 : 2'd0);
    end
    expWb = !hit && mValid[i] && (cur == 2'd2 || cur == 2'd3);
    @(negedge clk);
    cpuValid = 1; cpuWrite = wr; cpuAddr = a; sharedIn = sh; snpValid = 0;
    #1;
    chk(hit ? "R11" : rq, "cpuHit", int'(cpuHit), int'(hit));
    if (hit) chk("R11", "hitState", int'(hitState), int'(cur));
    chk(rq, "busValid", int'(busValid), int'(expBus));
    if (expBus) begin
      chk(rq, "busCmd", int'(busCmd), expCmd);
      chk(rq, "busAddr", int'(busAddr), int'(a));
    end
    chk("R10", "wbValid", int'(wbValid), int'(expWb));
    if (expWb) chk("R10", "wbAddr", int'(wbAddr), int'(wbA));
    chk(rq, "sharedOut", int'(sharedOut), 0);
    mState[i] = nxt;
    if (!hit) begin mValid[i] = 1; mTag[i] = t; end
  endtask

  task automatic doSnp(logic [1:0] cmd, logic [AW-1:0] a, string forceReq);
    int i = int'(a[IW-1:0]);
    bit hit = mValid[i] && mTag[i] == a[AW-1:IW];
    logic [1:0] cur = mState[i];
    bit act = hit && cmd != 2'd3;
    string rq;
    if (!act) rq = "R9";
    else if (cmd == 2'd0) rq = "R6";
    else if (cmd == 2'd1) rq = "R7";
    else rq = "R8";
    if (forceReq != "") rq = forceReq;
    @(negedge clk);
    cpuValid = 0; snpValid = 1; snpCmd = cmd; snpAddr = a; sharedIn = 0;
    #1;
    chk(rq, "sharedOut", int'(sharedOut), int'(act));
    chk(rq, "busValid", int'(busValid), 0);
    chk(rq, "wbValid", int'(wbValid), 0);
    if (act) begin
      if (cmd == 2'd0) mState[i] = (cur == 2'd3) ? 2'd2 : (cur == 2'd0) ? 2'd1 : cur;
      else mState[i] = 2'd1;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    cpuValid = 0; snpValid = 0; sharedIn = 0;
  endtask

  initial begin
    for (int i = 0; i < LN; i++) begin mValid[i] = 0; mTag[i] = '0; mState[i] = 2'd0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "busValid at reset", int'(busValid), 0);
    chk("R1", "sharedOut at reset", int'(sharedOut), 0);
    @(negedge clk);
    rstN = 1;
    // R1: all slots empty, no snoop hits anywhere
    for (int a = 0; a < (1 << AW); a++) doSnp(2'd0, AW'(a), "R1");
    // directed sweep: every start state x every operation
    for (int idx = 0; idx < LN; idx++) begin
      for (int s = 0; s < 4; s++) begin
        for (int op = 0; op < 9; op++) begin
          logic [TW-1:0] tA = TW'(idx + 1);
          logic [TW-1:0] tB = tA ^ TW'(5);
          logic [AW-1:0] aA = {tA, IW'(idx)};
          logic [AW-1:0] aB = {tB, IW'(idx)};
          doCpu(0, aB, 0);
          case (s)
            0: doCpu(0, aA, 0);
            1: doCpu(0, aA, 1);
            2: doCpu(1, aA, 1);
            default: doCpu(1, aA, 0);
          endcase
          case (op)
            0: doCpu(0, aA, 1);
            1: doCpu(1, aA, 0);
            2: doCpu(1, aA, 1);
            3: doSnp(2'd0, aA, "");
            4: doSnp(2'd1, aA, "");
            5: doSnp(2'd2, aA, "");
            6: doSnp(2'd3, aA, "");
            7: doCpu(0, aB, 0);
            default: doCpu(1, aB, 1);
          endcase
          doCpu(0, aA, 0);
        end
      end
    end
    // random mix over two tags per index
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] a = {TW'($urandom_range(0, 1)), IW'($urandom_range(0, LN - 1))};
      int k = $urandom_range(0, 5);
      if (k < 2) doCpu(bit'(k), a, bit'($urandom_range(0, 1)));
      else doSnp(2'($urandom_range(0, 3)), a, "");
    end
    idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule